// File: doc/BRIEF.md
# Synchronous Channel Framing Receiver

This block takes the serial bit stream of a synchronous data channel and splits it into fixed nine-bit words. Bits arrive on a data pin. They are taken in on a chosen edge of a data clock, and only while an input-enable strobe is high. The data clock and the strobe are plain inputs sampled by the system clock. The clock-mode pin picks the edge: falling when low, rising when high.

After reset the block hunts for the flag word. The flag is zero, seven ones, zero, in the order the bits arrive. It may start at any bit position. Once the flag is found, the word boundary is fixed and the status output goes high. From then on, each group of nine bits is sorted into one of four kinds:

- **Data word:** its payload goes to the receive FIFO with a one-cycle write pulse.
- **Flag word:** dropped with no output.
- **Break word:** raises a one-cycle break pulse.
- **Anything else:** ends framing, and the hunt starts again.

Nothing is written to the FIFO while the block is hunting.

Top module: `sc_sync_framer`

## Requirements
- R1: During and after synchronous reset, with no accepted bit, `sync_o`, `fifo_wr_o` and `brk_o` are all low.
- R2: With `cm` low, a bit is taken from `din` on each high-to-low change of `dclk`; with `cm` high, on each low-to-high change. A change is seen at the first system clock edge at which `dclk` shows its new level.
- R3: A `dclk` edge that occurs while `ie` is low takes no bit: word counting, framing and outputs are unaffected.
- R4: While `sync_o` is low no write pulse is issued, whatever words arrive.
- R5: When the last nine accepted bits, oldest first, are 0,1,1,1,1,1,1,1,0, `sync_o` rises after the clock edge that accepted the final bit. The next nine accepted bits form the first word.
- R6: A word whose first bit is 0 and whose ninth bit is 1 is a data word. Bits two to eight are payload, least significant first. `fifo_wr_o` pulses for one cycle with `fifo_data_o` carrying the payload, after the edge that accepted the ninth bit.
- R7: A flag word received while framed produces no write and no break, and `sync_o` stays high.
- R8: A framed word 1,1,1,1,1,1,1,1,0 pulses `brk_o` for one cycle, issues no write, and keeps `sync_o` high.
- R9: A framed word that is not data, flag or break drops `sync_o` after the edge that accepted its ninth bit, issues no write, and restarts the flag hunt on the following bits.
- R10: `fifo_wr_o` is a single-cycle pulse, issued once per data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dclk | input | 1 | Channel data clock, sampled by clk |
| cm | input | 1 | Clock mode: 0 takes bits on the falling dclk edge, 1 on the rising edge |
| ie | input | 1 | Input enable; dclk edges are ignored while low |
| din | input | 1 | Serial channel data |
| sync_o | output | 1 | High while word framing is held |
| fifo_wr_o | output | 1 | One-cycle write strobe for the receive FIFO |
| fifo_data_o | output | 7 | Payload of the word being written |
| brk_o | output | 1 | One-cycle break indication |

## Verification
The hardest state to reach is losing framing in the middle of a run and then finding it again. Getting there takes a bad word after framing was gained, then a data word that must not be written, then a flag at a new bit offset. The stimulus does exactly that. It also switches the clock mode while framed and pulses `dclk` with `ie` low between words. Those cases show whether edge selection and enable gating ever slip the word count by a bit. A behavioural model, built on queues of accepted bits, is compared with every output on every cycle.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    parameter int WORD_W = 9;
    localparam int DATA_W = WORD_W - 2;
    localparam int CNT_W  = $clog2(WORD_W);

    // bit WORD_W-1 holds the oldest accepted bit of the word
    localparam logic [WORD_W-1:0] FLAG_WORD  = {1'b0, {(WORD_W-2){1'b1}}, 1'b0};
    localparam logic [WORD_W-1:0] BREAK_WORD = {{(WORD_W-1){1'b1}}, 1'b0};

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [1:0] {
        W_FLAG,
        W_BREAK,
        W_DATA,
        W_BAD
    } word_kind_e;

    typedef struct packed {
        logic       valid;
        word_kind_e kind;
        data_t      data;
    } word_ev_t;

    function automatic word_kind_e classify(input word_t w);
        if (w == FLAG_WORD)                       return W_FLAG;
        if (w == BREAK_WORD)                      return W_BREAK;
        if (!w[WORD_W-1] && w[0])                 return W_DATA;
        return W_BAD;
    endfunction

    // payload travels least significant bit first, right after the start bit
    function automatic data_t payload(input word_t w);
        data_t d;
        for (int i = 0; i < DATA_W; i++) d[i] = w[WORD_W-2-i];
        return d;
    endfunction

endpackage

// File: rtl/sc_edge_sampler.sv
module sc_edge_sampler
    import sc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dclk,
    input  logic cm,
    input  logic ie,
    input  logic din,
    output logic bit_valid,
    output logic bit_val
);

    logic dclk_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) dclk_q <= 1'b0;
        else     dclk_q <= dclk;
    end

    assign rise      = dclk & ~dclk_q;
    assign fall      = ~dclk & dclk_q;
    assign bit_valid = ie & (cm ? rise : fall);
    assign bit_val   = din;

    // R2: two accepted bits are always at least two clocks apart
    a_r2_bit_spacing: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

endmodule

// File: rtl/sc_frame_tracker.sv
module sc_frame_tracker
    import sc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_valid,
    input  logic     bit_val,
    output logic     in_sync,
    output word_ev_t word_ev
);

    word_t    shift_q;
    word_t    shift_n;
    cnt_t     cnt_q;
    logic     sync_q;
    word_ev_t ev_q;

    assign shift_n = {shift_q[WORD_W-2:0], bit_val};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '1;
            cnt_q   <= '0;
            sync_q  <= 1'b0;
            ev_q    <= '0;
        end else begin
            ev_q.valid <= 1'b0;
            if (bit_valid) begin
                shift_q <= shift_n;
                if (!sync_q) begin
                    if (shift_n == FLAG_WORD) begin
                        sync_q <= 1'b1;
                        cnt_q  <= '0;
                    end
                end else if (cnt_q == cnt_t'(WORD_W-1)) begin
                    cnt_q <= '0;
                    if (classify(shift_n) == W_BAD) begin
                        sync_q <= 1'b0;
                    end else begin
                        ev_q.valid <= 1'b1;
                        ev_q.kind  <= classify(shift_n);
                        ev_q.data  <= payload(shift_n);
                    end
                end else begin
                    cnt_q <= cnt_q + cnt_t'(1);
                end
            end
        end
    end

    assign in_sync = sync_q;
    assign word_ev = ev_q;

    // R5: framing is only gained with a complete flag in the history
    a_r5_sync_on_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_q) |-> (shift_q == FLAG_WORD));

    // R4: no word event is ever produced while hunting
    a_r4_event_framed: assert property (@(posedge clk) disable iff (rst)
        ev_q.valid |-> sync_q);

    // R9: losing framing never coincides with an emitted word
    a_r9_loss_silent: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_q) |-> !ev_q.valid);

endmodule

// File: rtl/sc_sync_framer.sv
module sc_sync_framer
    import sc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dclk,
    input  logic              cm,
    input  logic              ie,
    input  logic              din,
    output logic              sync_o,
    output logic              fifo_wr_o,
    output logic [DATA_W-1:0] fifo_data_o,
    output logic              brk_o
);

    logic     bit_valid;
    logic     bit_val;
    word_ev_t ev;

    sc_edge_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .dclk      (dclk),
        .cm        (cm),
        .ie        (ie),
        .din       (din),
        .bit_valid (bit_valid),
        .bit_val   (bit_val)
    );

    sc_frame_tracker u_tracker (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_val   (bit_val),
        .in_sync   (sync_o),
        .word_ev   (ev)
    );

    // flag words are absorbed here: they never reach either strobe
    assign fifo_wr_o   = ev.valid && (ev.kind == W_DATA);
    assign brk_o       = ev.valid && (ev.kind == W_BREAK);
    assign fifo_data_o = ev.data;

    // R10: the write strobe never lasts two cycles
    a_r10_wr_single: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |=> !fifo_wr_o);

    // R8: break and write are never issued together
    a_r8_brk_excl: assert property (@(posedge clk) disable iff (rst)
        !(fifo_wr_o && brk_o));

    // R4: writes only happen while framed
    a_r4_wr_framed: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |-> sync_o);

    // R1: outputs are quiet in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!fifo_wr_o && !brk_o && !sync_o));

endmodule

// File: tb/sc_sync_framer_test.sv
module sc_sync_framer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dclk = 1'b0;
    logic       cm = 1'b0;
    logic       ie = 1'b0;
    logic       din = 1'b0;
    logic       sync_o, fifo_wr_o, brk_o;
    logic [6:0] fifo_data_o;

    int total = 0;
    int fails = 0;
    int wr_cnt = 0;
    int brk_cnt = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sc_sync_framer uut (
        .clk(clk), .rst(rst), .dclk(dclk), .cm(cm), .ie(ie), .din(din),
        .sync_o(sync_o), .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o),
        .brk_o(brk_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit m_prev = 0;
    bit m_sync = 0;
    bit e_wr = 0;
    bit e_brk = 0;
    int e_data = 0;
    bit hunt_q[$];
    bit word_q[$];

    always @(posedge clk) begin
        bit edge_seen;
        int v;
        e_wr  = 0;
        e_brk = 0;
        if (rst) begin
            m_prev = 0; m_sync = 0;
            hunt_q.delete(); word_q.delete();
        end else begin
            edge_seen = cm ? (!m_prev && dclk) : (m_prev && !dclk);
            m_prev = dclk;
            if (edge_seen && ie) begin
                if (!m_sync) begin
                    hunt_q.push_back(din);
                    if (hunt_q.size() > 9) void'(hunt_q.pop_front());
                    if (hunt_q.size() == 9) begin
                        v = 0;
                        foreach (hunt_q[i]) v = v * 2 + int'(hunt_q[i]);
                        if (v == 'h0FE) begin
                            m_sync = 1;
                            word_q.delete();
                        end
                    end
                end else begin
                    word_q.push_back(din);
                    if (word_q.size() == 9) begin
                        v = 0;
                        foreach (word_q[i]) v = v * 2 + int'(word_q[i]);
                        if (v == 'h0FE) begin
                        end else if (v == 'h1FE) begin
                            e_brk = 1;
                        end else if (!word_q[0] && word_q[8]) begin
                            e_wr = 1;
                            e_data = 0;
                            for (int i = 0; i < 7; i++)
                                if (word_q[1+i]) e_data = e_data | (1 << i);
                        end else begin
                            m_sync = 0;
                            hunt_q = word_q;
                        end
                        word_q.delete();
                    end
                end
            end
        end
    end

    bit last_wr = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(sync_o == m_sync, "R5/R9 sync_o", sync_o, m_sync);
            chk(fifo_wr_o == e_wr, "R6 fifo_wr_o", fifo_wr_o, e_wr);
            chk(brk_o == e_brk, "R8 brk_o", brk_o, e_brk);
            if (e_wr) chk(fifo_data_o == e_data[6:0], "R6 fifo_data_o", fifo_data_o, e_data);
            chk(!(last_wr && fifo_wr_o), "R10 strobe width", fifo_wr_o, 0);
            last_wr = fifo_wr_o;
            if (fifo_wr_o) wr_cnt++;
            if (brk_o) brk_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_bit(input bit b, input bit en);
        @(negedge clk); #1;
        din = b; ie = en; dclk = 1'b1;
        repeat (2) @(negedge clk);
        #1 dclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_word(input logic [8:0] w);
        for (int i = 8; i >= 0; i--) send_bit(w[i], 1'b1);
    endtask

    task automatic send_data(input logic [6:0] d);
        logic [8:0] w;
        w[8] = 1'b0;
        for (int i = 0; i < 7; i++) w[7-i] = d[i];
        w[0] = 1'b1;
        send_word(w);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            total++; fails++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        int w0;
        repeat (3) @(negedge clk);
        #1;
        // R1: outputs quiet while held in reset
        chk(!sync_o && !fifo_wr_o && !brk_o, "R1 reset outputs", {sync_o, fifo_wr_o, brk_o}, 0);
        rst = 1'b0;
        settle();
        chk(!sync_o && !fifo_wr_o && !brk_o, "R1 after reset", {sync_o, fifo_wr_o, brk_o}, 0);

        // R4: data words while hunting are never written
        send_data(7'h55);
        send_data(7'h0F);
        send_bit(1'b1, 1'b1);
        settle();
        chk(wr_cnt == 0, "R4 no write hunting", wr_cnt, 0);
        chk(sync_o == 1'b0, "R4 still hunting", sync_o, 0);

        // R5: flag at an odd offset gives framing
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1);
        send_word(9'b011111110);
        settle();
        chk(sync_o == 1'b1, "R5 framing found", sync_o, 1);

        // R6: data words written
        send_data(7'h55);
        send_data(7'h2A);
        send_data(7'h7F);
        send_data(7'h00);
        settle();
        chk(wr_cnt == 4, "R6 write count", wr_cnt, 4);

        // R7: framed flag dropped
        send_word(9'b011111110);
        settle();
        chk(wr_cnt == 4 && brk_cnt == 0, "R7 flag dropped", wr_cnt, 4);
        chk(sync_o == 1'b1, "R7 framing kept", sync_o, 1);

        // R8: break word
        send_word(9'b111111110);
        settle();
        chk(brk_cnt == 1 && wr_cnt == 4, "R8 break pulse", brk_cnt, 1);
        chk(sync_o == 1'b1, "R8 framing kept", sync_o, 1);

        // R3: edges with ie low take no bits
        for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
        settle();
        chk(sync_o == 1'b1 && wr_cnt == 4, "R3 ignored edges", wr_cnt, 4);
        send_data(7'h11);
        settle();
        chk(wr_cnt == 5, "R3 alignment kept", wr_cnt, 5);

        // R2: rising-edge mode
        cm = 1'b1;
        send_data(7'h3C);
        send_data(7'h41);
        settle();
        chk(wr_cnt == 7, "R2 rising mode writes", wr_cnt, 7);

        // R9: bad word drops framing, hunt restarts
        send_word(9'b000000000);
        settle();
        chk(sync_o == 1'b0, "R9 framing lost", sync_o, 0);
        w0 = wr_cnt;
        send_data(7'h3C);
        settle();
        chk(wr_cnt == w0, "R9 no write after loss", wr_cnt, w0);
        cm = 1'b0;
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        send_word(9'b011111110);
        send_data(7'h5A);
        settle();
        chk(sync_o == 1'b1 && wr_cnt == w0 + 1, "R9 reacquired", wr_cnt, w0 + 1);

        finish_run();
    end

endmodule